// File: doc/BRIEF.md
# Board Power-Rail Enable Sequencer

This block sits on the board side of a server SoC. It watches the SoC's three active-low sleep outputs: soft-off, suspend and memory-termination. It switches eight supply rails on and off in a fixed dependency order, and it returns the power-good signals the SoC waits on before it leaves reset. Each rail has one enable output and one power-good input. The analog ramp of a rail is not modelled. A rail counts as "good" when its power-good input is high while its enable is driven.

The ordering mixes two kinds of dependency. Some rails start as soon as a partner rail's enable is driven. Others wait until an earlier rail reports good. The SRAM rail has a hard start deadline counted from the moment both core rails are good. A per-rail watchdog raises a sticky fault if a rail does not come good in time. On a fault the block unwinds every enable in reverse order and holds every power-good low. All windows are counted in clock cycles, derived from a cycles-per-millisecond parameter.

Top module: `pwr_rail_sequencer`

## Requirements
- R1: While reset is held, every rail enable, both DRAM power-goods, the core power-good, both memory-analog power-goods and the fault flag are low, whatever the inputs do. The rail vector bit order is: 0 memory I/O, 1 core logic, 2 CPU core, 3 SRAM, 4 1.35 V, 5 1.0 V, 6 1.8 V, 7 3.3 V.
- R2: The memory I/O rail is enabled on the clock edge after the soft-off input is seen high. When soft-off is seen low, the DRAM power-goods, the core power-good and rails 1 to 7 drop on the next edge, and rail 0 drops one edge after that.
- R3: Both DRAM power-good outputs rise together, one edge after the memory I/O rail is enabled and good.
- R4: Rails 1 and 2 are enabled on the same edge, one edge after the DRAM power-goods are high. When the wait-for-sleep input is 1, this also waits until suspend and termination are both high. When that input is 0, those two inputs have no effect.
- R5: The 1.35 V rail is enabled on the same edge as the CPU-core rail.
- R6: The 1.0 V rail is enabled one edge after the core-logic rail is good, and never before. The 1.8 V rail is enabled on the same edge as the 1.0 V rail.
- R7: The SRAM rail is enabled one edge after both core rails are good. It is never enabled before that. It is never enabled later than SRAM_LIMIT_MS milliseconds after that.
- R8: The 3.3 V rail is enabled one edge after rails 1 to 6 are all good.
- R9: The core power-good and both memory-analog power-goods rise on the same edge. That edge comes one edge after all eight rails are good and the reference-clock-stable input is high. They do not rise while that input is low.
- R10: If a rail stays enabled without power-good for TIMEOUT_MS × CYC_PER_MS cycles, the fault flag rises on exactly that edge after the enable rose. All power-goods go low on the same edge.
- R11: After a fault, rail enables drop one per edge from rail 7 down to rail 0. The fault stays set, and no rail is re-enabled, until reset, even if soft-off toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slp_off_n | input | 1 | SoC soft-off sleep output, low = soft off |
| slp_susp_n | input | 1 | SoC suspend sleep output, low = asleep |
| slp_term_n | input | 1 | SoC memory-termination sleep output, low = off |
| wait_sleep | input | 1 | 1 = hold core rails until suspend and termination release |
| refclk_ok | input | 1 | Reference clocks are stable at the SoC |
| rail_pg | input | 8 | Per-rail power-good, bit order as in R1 |
| rail_en | output | 8 | Per-rail enable, bit order as in R1 |
| dram_pg | output | 2 | DRAM power-good pair |
| core_pg | output | 1 | Core power-good to the SoC |
| mema_pg | output | 2 | Memory analog power-good pair |
| fault | output | 1 | Sticky timeout fault |

## Verification
The bench plays the board. It releases power-goods one group at a time so that every "starts with" and "starts after good" link shows up as a separate step in the output order. A design that chained 1.35 V to CPU-core good, or 1.0 V to the enable rather than the good of the core-logic rail, would add or merge steps, and the scoreboard would catch the wrong vector. It holds the sleep pins and the clock-stable input low on purpose, to catch a sequencer that ignores the wait option or asserts core power-good early. It also releases them with the option off, to catch one that waits anyway. The fault run withholds only the 3.3 V good and measures the fault edge against the enable edge, so an off-by-one timer shows up. It then checks the one-per-edge reverse unwind and the stickiness under a soft-off toggle, which a design that restarted or dropped all rails at once would fail.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NRAIL    = 8;
  localparam int IDX_W    = $clog2(NRAIL);
  localparam int RL_MEMIO = 0;
  localparam int RL_VNN   = 1;
  localparam int RL_VCC   = 2;
  localparam int RL_SRAM  = 3;
  localparam int RL_V135  = 4;
  localparam int RL_V100  = 5;
  localparam int RL_V180  = 6;
  localparam int RL_V330  = 7;

  // millisecond window to clock cycles
  function automatic int unsigned ms_to_cyc(int unsigned cyc_per_ms, int unsigned ms);
    return cyc_per_ms * ms;
  endfunction

  // counter width able to hold lim
  function automatic int unsigned cnt_bits(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // core rails may start once the sleep pins allow it
  function automatic logic core_release(logic wait_sl, logic susp_n, logic term_n);
    return !wait_sl || (susp_n && term_n);
  endfunction

endpackage

// File: rtl/pwrseq_rail_watch.sv
module pwrseq_rail_watch #(
  parameter int unsigned NR    = 8,
  parameter int unsigned LIMIT = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NR-1:0] rail_en,
  input  logic [NR-1:0] rail_pg,
  output logic [NR-1:0] expired_vec,
  output logic          expire
);
  import pwrseq_pkg::*;

  localparam int unsigned CW = cnt_bits(LIMIT);

  for (genvar g = 0; g < NR; g++) begin : g_rail
    logic [CW-1:0] cnt;
    logic          waiting;

    assign waiting        = rail_en[g] && !rail_pg[g];
    assign expired_vec[g] = waiting && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!waiting)       cnt <= '0;
      else if (!expired_vec[g]) cnt <= cnt + 1'b1;
    end
  end

  assign expire = |expired_vec;

endmodule

// File: rtl/pwrseq_rail_ctrl.sv
module pwrseq_rail_ctrl
  import pwrseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slp_off_n,
  input  logic             slp_susp_n,
  input  logic             slp_term_n,
  input  logic             wait_sleep,
  input  logic             refclk_ok,
  input  logic [NRAIL-1:0] rail_pg,
  input  logic             expire,
  output logic [NRAIL-1:0] rail_en,
  output logic             dram_ok,
  output logic             core_ok,
  output logic             fault
);

  logic [NRAIL-1:0] ok;
  logic             ev_core_go;
  logic             ev_vnn_good;
  logic             ev_core_good;
  logic             ev_mid_good;
  logic             ev_all_good;
  logic [IDX_W-1:0] drop_idx;
  logic             drop_busy;

  // named sequencing events
  assign ok           = rail_en & rail_pg;
  assign ev_core_go   = dram_ok && core_release(wait_sleep, slp_susp_n, slp_term_n);
  assign ev_vnn_good  = ok[RL_VNN];
  assign ev_core_good = ok[RL_VNN] && ok[RL_VCC];
  assign ev_mid_good  = &ok[RL_V180:RL_VNN];
  assign ev_all_good  = (&ok) && refclk_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_en   <= '0;
      dram_ok   <= 1'b0;
      core_ok   <= 1'b0;
      fault     <= 1'b0;
      drop_idx  <= '0;
      drop_busy <= 1'b0;
    end else if (fault) begin
      // reverse unwind, one rail per edge
      if (drop_busy) begin
        rail_en[drop_idx] <= 1'b0;
        if (drop_idx == '0) drop_busy <= 1'b0;
        else                drop_idx  <= drop_idx - 1'b1;
      end
    end else if (expire) begin
      fault     <= 1'b1;
      dram_ok   <= 1'b0;
      core_ok   <= 1'b0;
      drop_busy <= 1'b1;
      drop_idx  <= IDX_W'(NRAIL - 1);
    end else if (!slp_off_n) begin
      dram_ok             <= 1'b0;
      core_ok             <= 1'b0;
      rail_en[NRAIL-1:1]  <= '0;
      if (!dram_ok) rail_en[RL_MEMIO] <= 1'b0;
    end else begin
      rail_en[RL_MEMIO] <= 1'b1;
      dram_ok           <= ok[RL_MEMIO];
      core_ok           <= ev_all_good;
      if (ev_core_go) begin
        rail_en[RL_VNN]  <= 1'b1;
        rail_en[RL_VCC]  <= 1'b1;
        rail_en[RL_V135] <= 1'b1;
      end
      if (ev_vnn_good) begin
        rail_en[RL_V100] <= 1'b1;
        rail_en[RL_V180] <= 1'b1;
      end
      if (ev_core_good) rail_en[RL_SRAM] <= 1'b1;
      if (ev_mid_good)  rail_en[RL_V330] <= 1'b1;
    end
  end

endmodule

// File: rtl/pwr_rail_sequencer.sv
module pwr_rail_sequencer #(
  parameter int unsigned CYC_PER_MS    = 125000,
  parameter int unsigned TIMEOUT_MS    = 2,
  parameter int unsigned SRAM_LIMIT_MS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slp_off_n,
  input  logic       slp_susp_n,
  input  logic       slp_term_n,
  input  logic       wait_sleep,
  input  logic       refclk_ok,
  input  logic [7:0] rail_pg,
  output logic [7:0] rail_en,
  output logic [1:0] dram_pg,
  output logic       core_pg,
  output logic [1:0] mema_pg,
  output logic       fault
);
  import pwrseq_pkg::*;

  localparam int unsigned TO_CYC   = ms_to_cyc(CYC_PER_MS, TIMEOUT_MS);
  localparam int unsigned SRAM_CYC = ms_to_cyc(CYC_PER_MS, SRAM_LIMIT_MS);

  logic [NRAIL-1:0] expired_vec;
  logic             expire;
  logic             dram_ok;
  logic             core_ok;

  pwrseq_rail_watch #(.NR(NRAIL), .LIMIT(TO_CYC)) u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .rail_en     (rail_en),
    .rail_pg     (rail_pg),
    .expired_vec (expired_vec),
    .expire      (expire)
  );

  pwrseq_rail_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slp_off_n  (slp_off_n),
    .slp_susp_n (slp_susp_n),
    .slp_term_n (slp_term_n),
    .wait_sleep (wait_sleep),
    .refclk_ok  (refclk_ok),
    .rail_pg    (rail_pg),
    .expire     (expire),
    .rail_en    (rail_en),
    .dram_ok    (dram_ok),
    .core_ok    (core_ok),
    .fault      (fault)
  );

  assign dram_pg = {2{dram_ok}};
  assign core_pg = core_ok;
  assign mema_pg = {2{core_ok}};

endmodule

// File: rtl/pwr_rail_sequencer_chk.sv
module pwr_rail_sequencer_chk #(
  parameter int unsigned SRAM_CYC = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       slp_off_n,
  input logic       refclk_ok,
  input logic [7:0] rail_pg,
  input logic [7:0] rail_en,
  input logic [1:0] dram_pg,
  input logic       core_pg,
  input logic [1:0] mema_pg,
  input logic       fault
);

  logic        core_both;
  int unsigned sram_wait;

  assign core_both = rail_en[1] && rail_en[2] && rail_pg[1] && rail_pg[2];

  always_ff @(posedge clk) begin
    if (!rst_n) sram_wait <= 0;
    else if (core_both && !rail_en[3] && !fault && slp_off_n) sram_wait <= sram_wait + 1;
    else sram_wait <= 0;
  end

  // R7
  sram_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_wait < SRAM_CYC);

  // R7
  sram_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_both && !fault && slp_off_n) |=> (rail_en[3] || fault || !rail_en[1]));

  // R5
  v135_with_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[2]) |-> rail_en[4]);

  // R6
  v100_after_vnn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[5]) |-> ($past(rail_pg[1]) && rail_en[6]));

  // R8
  v330_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[7]) |-> $past(&rail_pg[6:1]));

  // R3
  dram_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_pg[0]) |-> ($past(rail_pg[0]) && dram_pg[1]));

  // R9
  pg_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mema_pg[0] == core_pg) && (mema_pg[1] == core_pg));

  // R9
  core_pg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pg) |-> $past((&rail_pg) && refclk_ok));

  // R2
  memio_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[0]) |-> (dram_pg == 2'b00 && $past(dram_pg) == 2'b00));

  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!core_pg && dram_pg == 2'b00 && mema_pg == 2'b00));

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault) |-> fault);

  // R11
  drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && $past(fault)) |-> ($countones(rail_en ^ $past(rail_en)) <= 1 &&
                                 (rail_en & ~$past(rail_en)) == 8'h00));

endmodule

bind pwr_rail_sequencer pwr_rail_sequencer_chk #(.SRAM_CYC(SRAM_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slp_off_n (slp_off_n),
  .refclk_ok (refclk_ok),
  .rail_pg   (rail_pg),
  .rail_en   (rail_en),
  .dram_pg   (dram_pg),
  .core_pg   (core_pg),
  .mema_pg   (mema_pg),
  .fault     (fault)
);

// File: tb/test_pwr_rail_sequencer.sv
module test_pwr_rail_sequencer;

  localparam int unsigned CPM = 10;
  localparam int unsigned TMS = 4;
  localparam int unsigned TO  = CPM * TMS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slp_off_n = 1'b0, slp_susp_n = 1'b0, slp_term_n = 1'b0;
  logic       wait_sleep = 1'b1, refclk_ok = 1'b0;
  logic [7:0] rail_pg = '0;
  logic [7:0] rail_en;
  logic [1:0] dram_pg, mema_pg;
  logic       core_pg, fault;

  int checks = 0, fails = 0, cyc = 0, en7_cyc = 0, flt_cyc = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] en;
    logic       dram;
    logic       core;
    logic       flt;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  logic [13:0] last_vec = '0;

  pwr_rail_sequencer #(.CYC_PER_MS(CPM), .TIMEOUT_MS(TMS), .SRAM_LIMIT_MS(5)) i_pwr_rail_sequencer (
    .clk(clk), .rst_n(rst_n), .slp_off_n(slp_off_n), .slp_susp_n(slp_susp_n),
    .slp_term_n(slp_term_n), .wait_sleep(wait_sleep), .refclk_ok(refclk_ok),
    .rail_pg(rail_pg), .rail_en(rail_en), .dram_pg(dram_pg), .core_pg(core_pg),
    .mema_pg(mema_pg), .fault(fault)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] en, input logic dr, input logic co, input logic fl, input string tag);
    exp_t e;
    e.en = en; e.dram = dr; e.core = co; e.flt = fl; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every change of the output vector pops one expected item
  always @(negedge clk) begin
    logic [13:0] cur, expv;
    exp_t e;
    if (!rst_n) last_vec = '0;
    else begin
      cur = {rail_en, dram_pg, core_pg, mema_pg, fault};
      if (cur != last_vec) begin
        if (rail_en[7] && !last_vec[13]) en7_cyc = cyc;
        if (fault && !last_vec[0]) flt_cyc = cyc;
        if (exp_q.size() == 0) chk(1'b0, "unexpected change", int'(cur), int'(last_vec));
        else begin
          e = exp_q.pop_front();
          expv = {e.en, {2{e.dram}}, e.core, {2{e.core}}, e.flt};
          chk(cur === expv, e.tag, int'(cur), int'(expv));
        end
        last_vec = cur;
      end
    end
  end

  task automatic do_reset(input bit probe);
    @(negedge clk);
    rst_n = 1'b0;
    if (probe) begin
      slp_off_n = 1'b1; slp_susp_n = 1'b1; slp_term_n = 1'b1;
      rail_pg = 8'hFF; refclk_ok = 1'b1;
      step(3);
      // R1
      chk({rail_en, dram_pg, core_pg, mema_pg, fault} == 14'h0, "R1",
          int'({rail_en, dram_pg, core_pg, mema_pg, fault}), 0);
    end else step(3);
    slp_off_n = 1'b0; slp_susp_n = 1'b0; slp_term_n = 1'b0;
    rail_pg = '0; refclk_ok = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    // ---------- full power-up with sleep-pin wait enabled ----------
    wait_sleep = 1'b1;
    do_reset(1'b1);
    chk(rail_en == 8'h00 && !fault, "R1", int'(rail_en), 0);

    push(8'h01, 0, 0, 0, "R2");
    slp_off_n = 1'b1; step(3);
    push(8'h01, 1, 0, 0, "R3");
    rail_pg[0] = 1'b1; step(3);
    step(3);
    chk(rail_en == 8'h01, "R4 hold on sleep pins", int'(rail_en), 8'h01);
    slp_susp_n = 1'b1; step(3);
    chk(rail_en == 8'h01, "R4 hold on termination", int'(rail_en), 8'h01);
    push(8'h17, 1, 0, 0, "R4 R5");
    slp_term_n = 1'b1; step(3);
    chk(rail_en[5] == 1'b0, "R6 not before core-logic good", int'(rail_en), 8'h17);
    push(8'h77, 1, 0, 0, "R6");
    rail_pg[1] = 1'b1; step(3);
    chk(rail_en[3] == 1'b0, "R7 not before CPU-core good", int'(rail_en), 8'h77);
    push(8'h7F, 1, 0, 0, "R7");
    rail_pg[2] = 1'b1; step(3);
    push(8'hFF, 1, 0, 0, "R8");
    rail_pg[6:3] = 4'hF; step(3);
    rail_pg[7] = 1'b1; step(4);
    chk(core_pg == 1'b0, "R9 waits for refclk", int'(core_pg), 0);
    push(8'hFF, 1, 1, 0, "R9");
    refclk_ok = 1'b1; step(3);

    // soft-off entry
    push(8'h01, 0, 0, 0, "R2 power-goods first");
    push(8'h00, 0, 0, 0, "R2 memory rail second");
    slp_off_n = 1'b0; step(4);
    rail_pg = '0; refclk_ok = 1'b0; step(3);
    chk(exp_q.size() == 0, "R2 sequence complete", exp_q.size(), 0);

    // ---------- timeout on the 3.3 V rail, wait option off ----------
    wait_sleep = 1'b0;
    do_reset(1'b0);
    refclk_ok = 1'b1;
    rail_pg = 8'h7F;
    push(8'h01, 0, 0, 0, "R2");
    push(8'h01, 1, 0, 0, "R3");
    push(8'h17, 1, 0, 0, "R4 pins ignored");
    push(8'h7F, 1, 0, 0, "R7");
    push(8'hFF, 1, 0, 0, "R8");
    push(8'hFF, 0, 0, 1, "R10");
    for (int k = 1; k <= 8; k++) push(8'(8'hFF >> k), 0, 0, 1, "R11 reverse drop");
    slp_off_n = 1'b1;
    step(70);
    chk(flt_cyc - en7_cyc == int'(TO), "R10 timeout length", flt_cyc - en7_cyc, int'(TO));
    chk(exp_q.size() == 0, "R11 unwind complete", exp_q.size(), 0);
    slp_off_n = 1'b0; step(2);
    slp_off_n = 1'b1; step(6);
    chk(rail_en == 8'h00 && fault == 1'b1, "R11 sticky", int'({rail_en, fault}), 1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule